// File: doc/BRIEF.md
# Flash Command Access Sequencer

This block lets a host-side engine reach a device's settings flash through a small command window on a memory-mapped bus. The window holds a command/status register, a flash address register, a byte size register and a data window of quadlets. Each access is a single-beat bus transaction. The block drives that bus as master. On the other side it moves quadlets to and from a local quadlet buffer.

A request carries an operation, a flash byte address, a byte length and a start quadlet in the local buffer. Reads and writes are split into sub-blocks. For each sub-block the block issues the proper command code and waits a fixed settle time. It then polls the command/status register until it reads zero, and moves the data. Erase and revision-query requests issue a single command. Every request ends with a one-cycle `done` or `err` pulse.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `err`, `bm_req` and `buf_we` are low until a request is accepted.
- R2: A read request (`req_op`=0) handles each sub-block in this order. It writes the flash address to the address register, writes the sub-block byte count to the size register, writes code 0x2 to the command register, waits until ready, then reads the data window quadlet by quadlet. Each quadlet goes to consecutive local buffer locations, starting at `req_buf`.
- R3: A write request (`req_op`=1) handles each sub-block in this order. It first fills the data window from consecutive local buffer locations. It then writes the address register, the size register and command code 0x1.
- R4: Transfers are cut into sub-blocks of `SUB_Q` quadlets. The flash address advances by `4*SUB_Q` bytes per sub-block. A final partial sub-block reports and moves only the remaining quadlets, with no padding.
- R5: After a read, write or revision command is acknowledged, no status poll is issued for at least `WAIT_RW` cycles.
- R6: Three erase requests are supported, and none of them writes the address or size registers. Operation 2 writes 0xe (volumes), operation 3 writes 0xd (settings) and operation 4 writes 0xc (configuration). After an erase command, no poll is issued for at least `WAIT_ER` cycles.
- R7: The device counts as ready only when the command/status register reads zero. Any nonzero value leads to another poll.
- R8: A revision request (`req_op`=5) writes 0xf to the command register and waits for ready. It then reads one quadlet from the data window base and stores it at local location `req_buf`.
- R9: If `POLL_MAX` consecutive polls all read nonzero, the block pulses `err`, does not pulse `done`, and returns to idle.
- R10: `busy` rises in the cycle after a request is accepted and stays high until the `done` or `err` pulse. Requests presented while `busy` is high are ignored.
- R11: A read or write request of zero length, and any operation code of 6 or 7, ends with `done` and makes no bus access.
- R12: A bus request keeps its address, direction and write data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 3 | Operation: 0 read, 1 write, 2/3/4 erase, 5 revision |
| req_faddr | input | 32 | Flash byte address |
| req_len | input | LEN_W | Length in bytes (multiple of 4) |
| req_buf | input | BUF_AW | First local buffer quadlet |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle poll-timeout pulse |
| bm_req | output | 1 | Bus access request |
| bm_we | output | 1 | Bus access is a write |
| bm_addr | output | 32 | Bus byte address |
| bm_wdata | output | 32 | Bus write data |
| bm_ack | input | 1 | Bus access acknowledge |
| bm_rdata | input | 32 | Bus read data, valid with ack |
| buf_addr | output | BUF_AW | Local buffer quadlet address |
| buf_we | output | 1 | Local buffer write enable |
| buf_wdata | output | 32 | Local buffer write data |
| buf_rdata | input | 32 | Local buffer read data (combinational) |

## Verification
The stimulus goes after the split boundaries: lengths that are an exact multiple of a sub-block, one quadlet, and a partial tail after two full sub-blocks. A design that padded the tail or failed to advance the flash address would show a wrong final size value or wrong addresses. The poll limit is probed on both sides: one nonzero read fewer than the limit must finish, and exactly the limit must time out, which catches an off-by-one counter. The bus model stretches acknowledges by varying amounts, which exposes a master that changes its request before acknowledge. Poll timing is measured against the command write, so a shortened or skipped settle wait shows up as a short gap.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int BUF_AW = 8,
  parameter int LEN_W = 16,
  parameter int SUB_Q = 32,
  parameter int WAIT_RW = 500000,
  parameter int WAIT_ER = 125000000,
  parameter int POLL_MAX = 4096,
  parameter logic [31:0] WIN_BASE = 32'h0000_1000,
  parameter logic [31:0] CMD_OFS = 32'h0,
  parameter logic [31:0] ADDR_OFS = 32'h4,
  parameter logic [31:0] SIZE_OFS = 32'h8,
  parameter logic [31:0] DATA_OFS = 32'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [31:0]       req_faddr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [BUF_AW-1:0] req_buf,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              bm_req,
  output logic              bm_we,
  output logic [31:0]       bm_addr,
  output logic [31:0]       bm_wdata,
  input  logic              bm_ack,
  input  logic [31:0]       bm_rdata,
  output logic [BUF_AW-1:0] buf_addr,
  output logic              buf_we,
  output logic [31:0]       buf_wdata,
  input  logic [31:0]       buf_rdata
);
  localparam int QW = $clog2(SUB_Q + 1);
  localparam int RW = LEN_W - 2;
  localparam int WW = $clog2(WAIT_ER + 1);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam logic [31:0] SUB_B = 32'(SUB_Q * 4);

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_ADDR, S_SIZE, S_CMD, S_WAIT, S_POLL, S_RDAT, S_FIN
  } st_t;

  st_t st;
  logic [2:0]        op;
  logic [31:0]       fa;
  logic [RW-1:0]     rem;
  logic [QW-1:0]     cnt;
  logic [BUF_AW-1:0] bp;
  logic [WW-1:0]     wcnt;
  logic [PW-1:0]     pcnt;
  logic              done_q, err_q;
  logic [3:0]        code;

  wire            big     = rem > RW'(SUB_Q);
  wire [QW-1:0]   subq    = big ? QW'(SUB_Q) : rem[QW-1:0];
  wire            sub_end = cnt == subq - QW'(1);
  wire            is_er   = (op == 3'd2) || (op == 3'd3) || (op == 3'd4);
  wire [WW-1:0]   lim     = is_er ? WW'(WAIT_ER - 1) : WW'(WAIT_RW - 1);
  wire [31:0]     dat_a   = WIN_BASE + DATA_OFS + (32'(cnt) << 2);

  always_comb begin
    case (op)
      3'd0:    code = 4'h2;
      3'd1:    code = 4'h1;
      3'd2:    code = 4'he;
      3'd3:    code = 4'hd;
      3'd4:    code = 4'hc;
      default: code = 4'hf;
    endcase
  end

  assign busy      = st != S_IDLE;
  assign done      = done_q;
  assign err       = err_q;
  assign bm_req    = st inside {S_LOAD, S_ADDR, S_SIZE, S_CMD, S_POLL, S_RDAT};
  assign bm_we     = st inside {S_LOAD, S_ADDR, S_SIZE, S_CMD};
  assign buf_addr  = bp;
  assign buf_we    = (st == S_RDAT) && bm_ack;
  assign buf_wdata = bm_rdata;

  always_comb begin
    bm_addr  = WIN_BASE + CMD_OFS;
    bm_wdata = 32'h0;
    case (st)
      S_LOAD: begin bm_addr = dat_a; bm_wdata = buf_rdata; end
      S_ADDR: begin bm_addr = WIN_BASE + ADDR_OFS; bm_wdata = fa; end
      S_SIZE: begin bm_addr = WIN_BASE + SIZE_OFS; bm_wdata = 32'(subq) << 2; end
      S_CMD:  bm_wdata = 32'(code);
      S_RDAT: bm_addr = dat_a;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= 3'd0; fa <= '0; rem <= '0; cnt <= '0; bp <= '0;
      wcnt <= '0; pcnt <= '0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op <= req_op; fa <= req_faddr; rem <= req_len[LEN_W-1:2];
          bp <= req_buf; cnt <= '0;
          if (req_op > 3'd5) st <= S_FIN;
          else if (req_op > 3'd1) st <= S_CMD;
          else if (req_len[LEN_W-1:2] == '0) st <= S_FIN;
          else st <= (req_op == 3'd1) ? S_LOAD : S_ADDR;
        end
        S_LOAD: if (bm_ack) begin
          bp <= bp + 1'b1;
          if (sub_end) begin cnt <= '0; st <= S_ADDR; end
          else cnt <= cnt + 1'b1;
        end
        S_ADDR: if (bm_ack) st <= S_SIZE;
        S_SIZE: if (bm_ack) st <= S_CMD;
        S_CMD:  if (bm_ack) begin wcnt <= '0; st <= S_WAIT; end
        S_WAIT: begin
          if (wcnt == lim) begin pcnt <= '0; st <= S_POLL; end
          else wcnt <= wcnt + 1'b1;
        end
        S_POLL: if (bm_ack) begin
          if (bm_rdata == 32'h0) begin
            if (is_er) st <= S_FIN;
            else if (op == 3'd1) begin
              rem <= rem - RW'(subq); fa <= fa + SUB_B;
              st <= big ? S_LOAD : S_FIN;
            end else begin cnt <= '0; st <= S_RDAT; end
          end else if (pcnt == PW'(POLL_MAX - 1)) begin
            err_q <= 1'b1; st <= S_IDLE;
          end else pcnt <= pcnt + 1'b1;
        end
        S_RDAT: if (bm_ack) begin
          bp <= bp + 1'b1;
          if (op == 3'd5) st <= S_FIN;
          else if (sub_end) begin
            cnt <= '0; rem <= rem - RW'(subq); fa <= fa + SUB_B;
            st <= big ? S_ADDR : S_FIN;
          end else cnt <= cnt + 1'b1;
        end
        S_FIN: begin done_q <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        bm_req,
  input logic        bm_ack,
  input logic        bm_we,
  input logic [31:0] bm_addr,
  input logic [31:0] bm_wdata,
  input logic        buf_we
);
  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bm_req);
  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || err));
  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && !bm_ack) |=> (bm_req && $stable(bm_addr) && $stable(bm_we) && $stable(bm_wdata)));
  // R2
  buf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (bm_ack && !bm_we));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .err(err), .bm_req(bm_req), .bm_ack(bm_ack), .bm_we(bm_we),
  .bm_addr(bm_addr), .bm_wdata(bm_wdata), .buf_we(buf_we)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int WRW = 20;
  localparam int WER = 60;
  localparam int PMAX = 6;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] REV = 32'h00C0_FFEE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [31:0] req_faddr = 32'h0;
  logic [15:0] req_len = 16'h0;
  logic [7:0] req_buf = 8'h0;
  logic busy, done, err, bm_req, bm_we, buf_we;
  logic [31:0] bm_addr, bm_wdata, buf_wdata;
  logic [7:0] buf_addr;
  logic ack = 1'b0;
  logic [31:0] rd = 32'h0;
  logic [31:0] lbuf [256];
  logic [31:0] flash [1024];
  logic [31:0] win [64];

  always #2 clk = ~clk;

  flash_cmd_seq #(.BUF_AW(8), .LEN_W(16), .SUB_Q(32), .WAIT_RW(WRW), .WAIT_ER(WER),
    .POLL_MAX(PMAX), .WIN_BASE(BASE)) i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_faddr(req_faddr), .req_len(req_len), .req_buf(req_buf),
    .busy(busy), .done(done), .err(err), .bm_req(bm_req), .bm_we(bm_we),
    .bm_addr(bm_addr), .bm_wdata(bm_wdata), .bm_ack(ack), .bm_rdata(rd),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .buf_rdata(lbuf[buf_addr]));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) lbuf[i] <= 32'h5A00_0000 + 32'(i);
    end else if (buf_we) lbuf[buf_addr] <= buf_wdata;

  int busy_polls = 2;
  int ev_k [4096];
  int unsigned ev_v [4096];
  int n_ev = 0;
  int hold_bad = 0;
  bit minit = 1'b0;
  bit pend = 1'b0, fpend = 1'b0;
  logic [31:0] h_a, h_d, areg, sreg;
  logic h_w;
  int wt = 0, stat = 0, last_cmd = 0;

  task automatic log_ev(input int k, input int unsigned v);
    ev_k[n_ev] = k; ev_v[n_ev] = v; n_ev++;
  endtask

  always @(negedge clk) begin
    if (!minit) begin
      for (int i = 0; i < 1024; i++) flash[i] = 32'hF1A5_0000 + 32'(i * 7);
      minit = 1'b1;
    end
    if (!rst_n) begin ack = 1'b0; pend = 1'b0; end
    else if (ack) ack = 1'b0;
    else if (bm_req) begin
      if (!pend) begin
        pend = 1'b1; h_a = bm_addr; h_w = bm_we; h_d = bm_wdata; wt = cyc % 3;
      end else if (h_a != bm_addr || h_w != bm_we || h_d != bm_wdata) hold_bad++;
      if (wt == 0) begin
        ack = 1'b1; pend = 1'b0;
        if (h_w) begin
          if (h_a == BASE) begin
            log_ev(3, h_d); last_cmd = cyc; fpend = 1'b1; stat = busy_polls;
            if (h_d == 32'h2)
              for (int i = 0; i < 32; i++) begin
                if (i < int'(sreg >> 2)) win[i] = flash[((areg >> 2) + 32'(i)) & 32'h3ff];
              end
            else if (h_d == 32'h1)
              for (int i = 0; i < 32; i++) begin
                if (i < int'(sreg >> 2)) flash[((areg >> 2) + 32'(i)) & 32'h3ff] = win[i];
              end
            else if (h_d == 32'hf) win[0] = REV;
          end else if (h_a == BASE + 32'h4) begin areg = h_d; log_ev(1, h_d); end
          else if (h_a == BASE + 32'h8) begin sreg = h_d; log_ev(2, h_d); end
          else begin win[((h_a - BASE - 32'h40) >> 2) & 32'h3f] = h_d; log_ev(4, h_d); end
        end else begin
          if (h_a == BASE) begin
            rd = (stat != 0) ? 32'h1 : 32'h0;
            if (stat != 0) stat--;
            log_ev(fpend ? 7 : 6, cyc - last_cmd); fpend = 1'b0;
          end else begin
            rd = win[((h_a - BASE - 32'h40) >> 2) & 32'h3f]; log_ev(5, rd);
          end
        end
      end else wt--;
    end
  end

  int nchk = 0, nerr = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  initial begin
    #600000;
    nerr++; nchk++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  int base = 0;
  bit got_done, got_err;
  int a_cmd, a_lastsz, a_sum, a_as, a_data, a_poll, a_gap, a_lastcode, a_order;
  bit a_addr_ok;

  task automatic start_op(input logic [2:0] o, input logic [31:0] f, input logic [15:0] l, input logic [7:0] b);
    base = n_ev;
    @(negedge clk);
    req_valid = 1'b1; req_op = o; req_faddr = f; req_len = l; req_buf = b;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end();
    got_done = 1'b0; got_err = 1'b0;
    while (!done && !err) @(negedge clk);
    got_done = done; got_err = err;
    @(negedge clk);
  endtask

  task automatic analyze(input logic [31:0] f);
    int k;
    a_cmd = 0; a_lastsz = 0; a_sum = 0; a_as = 0; a_data = 0; a_poll = 0;
    a_gap = 1000000; a_lastcode = -1; a_addr_ok = 1'b1; k = 0; a_order = 0;
    for (int i = base; i < n_ev; i++) begin
      case (ev_k[i])
        1: begin a_as++; if (ev_v[i] != f + 32'(128 * k)) a_addr_ok = 1'b0; k++; end
        2: begin a_as++; a_lastsz = int'(ev_v[i]); a_sum += int'(ev_v[i]); end
        3: begin a_cmd++; a_lastcode = int'(ev_v[i]); end
        4, 5: a_data++;
        6: a_poll++;
        7: begin a_poll++; if (int'(ev_v[i]) < a_gap) a_gap = int'(ev_v[i]); end
        default: ;
      endcase
    end
  endtask

  localparam logic [63:0] VEC [5] = '{
    {8'd1, 32'h0000_0100, 16'd160, 8'd0},
    {8'd0, 32'h0000_0100, 16'd160, 8'd64},
    {8'd0, 32'h0000_0000, 16'd128, 8'd128},
    {8'd1, 32'h0000_0800, 16'd4,   8'd10},
    {8'd0, 32'h0000_0200, 16'd280, 8'd160}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, done, err, bm_req, buf_we} == 5'b0, "R1 reset outputs",
        {27'h0, busy, done, err, bm_req, buf_we}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, done, err, bm_req, buf_we} == 5'b0, "R1 idle after reset",
        {27'h0, busy, done, err, bm_req, buf_we}, 32'h0);

    for (int v = 0; v < 5; v++) begin
      logic [2:0] o; logic [31:0] f; logic [15:0] l; logic [7:0] b;
      int q, ns, lastb, first, dbad;
      o = VEC[v][58:56]; f = VEC[v][55:24]; l = VEC[v][23:8]; b = VEC[v][7:0];
      q = int'(l) / 4; ns = (q + 31) / 32; lastb = (q % 32 == 0) ? 128 : (q % 32) * 4;
      start_op(o, f, l, b);
      wait_end();
      analyze(f);
      chk(got_done && !got_err && !busy, "R10 done and idle", {30'h0, got_done, got_err}, 32'h2);
      dbad = 0;
      for (int i = 0; i < q; i++)
        if (flash[((f >> 2) + 32'(i)) & 32'h3ff] != lbuf[(b + 8'(i))]) dbad++;
      chk(dbad == 0, (o == 3'd1) ? "R3 written data" : "R2 read data", dbad, 0);
      chk(a_cmd == ns && a_addr_ok, "R4 sub-block count and addresses", a_cmd, ns);
      chk(a_lastsz == lastb && a_sum == int'(l), "R4 unpadded last size", a_lastsz, lastb);
      chk(a_data == q, "R4 quadlets moved", a_data, q);
      first = (q < 32) ? q : 32;
      if (o == 3'd1)
        chk(ev_k[base] == 4 && ev_k[base + first] == 1 && ev_k[base + first + 1] == 2 &&
            ev_k[base + first + 2] == 3 && a_lastcode == 1, "R3 order and code",
            ev_k[base + first + 2], 3);
      else
        chk(ev_k[base] == 1 && ev_k[base + 1] == 2 && ev_k[base + 2] == 3 && a_lastcode == 2,
            "R2 order and code", ev_k[base + 2], 3);
      chk(a_gap >= WRW, "R5 settle before poll", a_gap, WRW);
      chk(a_poll == ns * 3, "R7 polls until zero", a_poll, ns * 3);
    end

    for (int e = 0; e < 3; e++) begin
      int expc;
      expc = 14 - e;
      start_op(3'(2 + e), 32'h0, 16'd0, 8'd0);
      wait_end();
      analyze(32'h0);
      chk(got_done && a_cmd == 1 && a_lastcode == expc && a_as == 0, "R6 erase code",
          a_lastcode, expc);
      chk(a_gap >= WER, "R6 erase settle", a_gap, WER);
    end

    start_op(3'd5, 32'h0, 16'd0, 8'd250);
    wait_end();
    analyze(32'h0);
    chk(got_done && a_lastcode == 15 && a_as == 0 && a_data == 1, "R8 revision sequence",
        a_lastcode, 15);
    chk(lbuf[250] == REV, "R8 revision value", lbuf[250], REV);
    chk(a_gap >= WRW, "R5 revision settle", a_gap, WRW);

    busy_polls = PMAX - 1;
    start_op(3'd3, 32'h0, 16'd0, 8'd0);
    wait_end();
    analyze(32'h0);
    chk(got_done && !got_err && a_poll == PMAX, "R7 ready on last allowed poll", a_poll, PMAX);

    busy_polls = PMAX;
    start_op(3'd3, 32'h0, 16'd0, 8'd0);
    wait_end();
    analyze(32'h0);
    chk(got_err && !got_done && !busy && a_poll == PMAX, "R9 poll limit error",
        {got_err, got_done, 30'(a_poll)}, {2'b10, 30'(PMAX)});
    busy_polls = 2;

    start_op(3'd0, 32'h0, 16'd0, 8'd0);
    wait_end();
    analyze(32'h0);
    chk(got_done && (n_ev - base) == 0, "R11 zero length", n_ev - base, 0);
    start_op(3'd7, 32'h100, 16'd64, 8'd0);
    wait_end();
    analyze(32'h0);
    chk(got_done && (n_ev - base) == 0, "R11 unused op code", n_ev - base, 0);

    start_op(3'd0, 32'h0000_0300, 16'd160, 8'd0);
    repeat (10) @(negedge clk);
    req_valid = 1'b1; req_op = 3'd2;
    @(negedge clk);
    req_valid = 1'b0;
    wait_end();
    analyze(32'h0000_0300);
    chk(got_done && a_cmd == 2 && a_lastcode == 2 && a_addr_ok, "R10 request ignored while busy",
        a_cmd, 2);

    chk(hold_bad == 0, "R12 request held until ack", hold_bad, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule